// File: doc/BRIEF.md
# Flash Command Sequencer with Toggle-Bit Completion Polling

This block drives a byte-wide memory port on behalf of a parallel flash device that takes its orders as short scripts of writes to magic offsets. A client presents an operation code and its operands and pulses `start`. The block then issues the unlock writes, the command writes and any reads for that operation. After a program or erase command, it waits for the device to finish by reading offset 0 again and again until status bit 6 stops changing between two successive reads.

The memory port uses a simple request/acknowledge handshake. `mem_req` stays high with a stable address, direction and write byte until the device side returns `mem_ack` for one cycle. Read data is valid on `mem_rdata` in that acknowledge cycle. The block has five states:

- IDLE accepts `start`.
- ACCESS presents the current script step. If the step is the end marker, ACCESS moves either to the next sector or to DONE.
- ADVANCE decides what follows an acknowledged access: the next step, another poll read, a timeout, or a wait.
- GAP holds the programmed number of cycles between erase polls.
- DONE raises `done` for one cycle and then returns to IDLE.

Completion comes only from matching status reads. No ready pin exists. A poll-count limit turns a device that never settles into a timeout. A block erase can also be carried out as a run of sector erases over every sector inside the block, for devices that have no block erase command.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `mem_req` are low, and `ven_id` and `dev_id` are 8'h00.
- R2: Every operation with code 0 to 4 begins with a write of 8'hAA to offset 16'h5555 followed by a write of 8'h55 to offset 16'h2AAA. A pending request holds address, direction and data stable until it is acknowledged.
- R3: Code 0 (identify) continues with these accesses, in order:
  - a write of 8'h90 to 16'h5555;
  - a read of offset 0, whose byte appears on `ven_id`;
  - a read of offset 1, whose byte appears on `dev_id`;
  - a write of 8'hF0 to offset 0.
- R4: Code 1 (program) continues with a write of 8'hA0 to 16'h5555, then writes `prog_data` at `prog_addr`, then polls.
- R5: Codes 2, 3 and 4 (sector, block and chip erase) continue with these writes, in order, and then poll:
  - 8'h80 to 16'h5555;
  - 8'hAA to 16'h5555;
  - 8'h55 to 16'h2AAA;
  - a final write. For code 2 the final write is 8'h30 at `index << sec_log2`. For code 3 it is 8'h50 at `index << blk_log2`. For code 4 it is 8'h10 at 16'h5555.
- R6: A poll is a read of offset 0 that uses only bit 6 of the returned byte. Polling ends when a read's bit 6 equals the previous read's bit 6. The first read of each poll never ends it, so every poll makes at least two reads.
- R7: After a non-final poll read of an erase, the port is idle for 1 + `poll_gap` cycles before the next poll read. For a program the port is idle for exactly 1 cycle, whatever `poll_gap` is.
- R8: When `POLL_LIMIT` poll reads have not matched their predecessor, the operation ends with `done`, `timeout` goes high, and no further access is issued.
- R9: With `blk_split` high, code 3 is carried out as complete sector erases (R5, code 2 form) of sectors `(index << (blk_log2 - sec_log2))` up to, but not including, `((index+1) << (blk_log2 - sec_log2))`, in increasing order. This mode requires `blk_log2 >= sec_log2`.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse and is never high together with `busy`. A `start` while busy is ignored. Codes 5 to 7 make no access and finish with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code: 0 identify, 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| index | input | IDX_W | Sector or block number |
| sec_log2 | input | 5 | log2 of sector size in bytes |
| blk_log2 | input | 5 | log2 of block size in bytes |
| blk_split | input | 1 | Perform block erase as a run of sector erases |
| prog_addr | input | ADDR_W | Program target offset |
| prog_data | input | 8 | Program data byte |
| poll_gap | input | GAP_W | Idle cycles added between erase polls |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last operation hit the poll limit |
| ven_id | output | 8 | Vendor byte from the last identify |
| dev_id | output | 8 | Device byte from the last identify |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory offset |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |

## Verification
Two things can coincide in the same cycle. A new `start` can arrive while a script is in flight, and a poll can reach its limit on the very read that would otherwise be the last mismatch. The bench pulses `start` with a different code and index in the middle of a program, then confirms that the logged access stream matches the first request exactly. It also sets the device model's busy length equal to, and just below, the poll limit. It then judges the outcome from the number of poll reads logged and the `timeout` level at `done`.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDENT = 3'd0,
        OP_PROG  = 3'd1,
        OP_SECT  = 3'd2,
        OP_BLOCK = 3'd3,
        OP_CHIP  = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        K_WR,
        K_RD_VEN,
        K_RD_DEV,
        K_POLL,
        K_END
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACCESS,
        S_ADVANCE,
        S_GAP,
        S_DONE
    } state_e;

    localparam logic [15:0] OFS_KEY_A = 16'h5555;
    localparam logic [15:0] OFS_KEY_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A     = 8'hAA;
    localparam logic [7:0]  KEY_B     = 8'h55;
    localparam logic [7:0]  CMD_ID    = 8'h90;
    localparam logic [7:0]  CMD_EXIT  = 8'hF0;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERSU  = 8'h80;
    localparam logic [7:0]  FIN_SECT  = 8'h30;
    localparam logic [7:0]  FIN_BLOCK = 8'h50;
    localparam logic [7:0]  FIN_CHIP  = 8'h10;

endpackage

// File: rtl/flash_script.sv
module flash_script
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int STEP_W = 4
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        prog_byte,
    output kind_e             kind,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);

    localparam logic [ADDR_W-1:0] A_KA = ADDR_W'(OFS_KEY_A);
    localparam logic [ADDR_W-1:0] A_KB = ADDR_W'(OFS_KEY_B);

    logic [7:0] fin_byte;

    always_comb begin
        unique case (op)
            OP_SECT:  fin_byte = FIN_SECT;
            OP_BLOCK: fin_byte = FIN_BLOCK;
            default:  fin_byte = FIN_CHIP;
        endcase
    end

    always_comb begin
        kind = K_END;
        addr = '0;
        data = '0;
        unique case (op)
            OP_IDENT: begin
                unique case (int'(step))
                    0:       begin kind = K_WR;     addr = A_KA; data = KEY_A;    end
                    1:       begin kind = K_WR;     addr = A_KB; data = KEY_B;    end
                    2:       begin kind = K_WR;     addr = A_KA; data = CMD_ID;   end
                    3:       begin kind = K_RD_VEN; addr = '0;                    end
                    4:       begin kind = K_RD_DEV; addr = ADDR_W'(1);            end
                    5:       begin kind = K_WR;     addr = '0;   data = CMD_EXIT; end
                    default: kind = K_END;
                endcase
            end
            OP_PROG: begin
                unique case (int'(step))
                    0:       begin kind = K_WR;   addr = A_KA;     data = KEY_A;     end
                    1:       begin kind = K_WR;   addr = A_KB;     data = KEY_B;     end
                    2:       begin kind = K_WR;   addr = A_KA;     data = CMD_PROG;  end
                    3:       begin kind = K_WR;   addr = tgt_addr; data = prog_byte; end
                    4:       begin kind = K_POLL; addr = '0;                         end
                    default: kind = K_END;
                endcase
            end
            OP_SECT, OP_BLOCK, OP_CHIP: begin
                unique case (int'(step))
                    0:       begin kind = K_WR;   addr = A_KA;     data = KEY_A;    end
                    1:       begin kind = K_WR;   addr = A_KB;     data = KEY_B;    end
                    2:       begin kind = K_WR;   addr = A_KA;     data = CMD_ERSU; end
                    3:       begin kind = K_WR;   addr = A_KA;     data = KEY_A;    end
                    4:       begin kind = K_WR;   addr = A_KB;     data = KEY_B;    end
                    5:       begin kind = K_WR;   addr = tgt_addr; data = fin_byte; end
                    6:       begin kind = K_POLL; addr = '0;                        end
                    default: kind = K_END;
                endcase
            end
            default: kind = K_END;
        endcase
    end

endmodule

// File: rtl/flash_poll.sv
module flash_poll #(
    parameter int LIMIT = 64,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             bit_in,
    input  logic             gap_load,
    input  logic [GAP_W-1:0] gap_val,
    output logic             match,
    output logic             limit_hit,
    output logic             gap_last
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic             saved_v;
    logic             saved_b;
    logic             match_q;
    logic [CNT_W-1:0] miss_cnt;
    logic [GAP_W-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_v  <= 1'b0;
            saved_b  <= 1'b0;
            match_q  <= 1'b0;
            miss_cnt <= '0;
        end else if (clear) begin
            saved_v  <= 1'b0;
            match_q  <= 1'b0;
            miss_cnt <= '0;
        end else if (sample) begin
            if (saved_v && (bit_in == saved_b)) begin
                match_q <= 1'b1;
            end else begin
                match_q <= 1'b0;
                saved_b <= bit_in;
                saved_v <= 1'b1;
                if (miss_cnt != CNT_W'(LIMIT))
                    miss_cnt <= miss_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (gap_load)
            gap_cnt <= gap_val;
        else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - GAP_W'(1);
    end

    assign match     = match_q;
    assign limit_hit = (miss_cnt >= CNT_W'(LIMIT));
    assign gap_last  = (gap_cnt == GAP_W'(1));

    a_r8_miss_capped: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt <= CNT_W'(LIMIT));

    a_r6_match_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !match_q);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int IDX_W      = 8,
    parameter int GAP_W      = 8,
    parameter int POLL_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [IDX_W-1:0]  index,
    input  logic [4:0]        sec_log2,
    input  logic [4:0]        blk_log2,
    input  logic              blk_split,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [7:0]        ven_id,
    output logic [7:0]        dev_id,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);

    localparam int STEP_W = 4;

    state_e              state, state_n;
    op_e                 eff_op;
    logic [STEP_W-1:0]   step;
    logic [IDX_W-1:0]    idx_q;
    logic [4:0]          slog_q, blog_q;
    logic [ADDR_W-1:0]   padr_q;
    logic [7:0]          pdat_q;
    logic [GAP_W-1:0]    gap_q;
    logic [ADDR_W-1:0]   sec_cur, sec_left;
    kind_e               last_kind;
    logic                timeout_q;
    logic [7:0]          ven_q, dev_q;

    kind_e               kind;
    logic [ADDR_W-1:0]   s_addr, tgt_addr;
    logic [7:0]          s_data;
    logic                p_match, p_limit, p_gap_last;
    logic                is_erase, step_adv, to_hit, split_go;
    logic [4:0]          diff;

    assign is_erase = (eff_op == OP_SECT) || (eff_op == OP_BLOCK) || (eff_op == OP_CHIP);
    assign step_adv = (state == S_ADVANCE) && ((last_kind != K_POLL) || p_match);
    assign to_hit   = (state == S_ADVANCE) && (last_kind == K_POLL) && !p_match && p_limit;
    assign split_go = (op_e'(op) == OP_BLOCK) && blk_split;
    assign diff     = blk_log2 - sec_log2;

    always_comb begin
        unique case (eff_op)
            OP_PROG:  tgt_addr = padr_q;
            OP_SECT:  tgt_addr = sec_cur << slog_q;
            OP_BLOCK: tgt_addr = ADDR_W'(idx_q) << blog_q;
            default:  tgt_addr = ADDR_W'(OFS_KEY_A);
        endcase
    end

    flash_script #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_script (
        .op        (eff_op),
        .step      (step),
        .tgt_addr  (tgt_addr),
        .prog_byte (pdat_q),
        .kind      (kind),
        .addr      (s_addr),
        .data      (s_data)
    );

    flash_poll #(.LIMIT(POLL_LIMIT), .GAP_W(GAP_W)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (((state == S_IDLE) && start) || step_adv),
        .sample    ((state == S_ACCESS) && mem_ack && (kind == K_POLL)),
        .bit_in    (mem_rdata[6]),
        .gap_load  ((state == S_ADVANCE) && (state_n == S_GAP)),
        .gap_val   (gap_q),
        .match     (p_match),
        .limit_hit (p_limit),
        .gap_last  (p_gap_last)
    );

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:    if (start) state_n = S_ACCESS;
            S_ACCESS: begin
                if (kind == K_END) begin
                    if (sec_left == '0) state_n = S_DONE;
                end else if (mem_ack) begin
                    state_n = S_ADVANCE;
                end
            end
            S_ADVANCE: begin
                if (step_adv)                     state_n = S_ACCESS;
                else if (p_limit)                 state_n = S_DONE;
                else if (is_erase && gap_q != '0) state_n = S_GAP;
                else                              state_n = S_ACCESS;
            end
            S_GAP:     if (p_gap_last) state_n = S_ACCESS;
            S_DONE:    state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // operand capture and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_op    <= OP_IDENT;
            step      <= '0;
            idx_q     <= '0;
            slog_q    <= '0;
            blog_q    <= '0;
            padr_q    <= '0;
            pdat_q    <= '0;
            gap_q     <= '0;
            sec_cur   <= '0;
            sec_left  <= '0;
            last_kind <= K_END;
            timeout_q <= 1'b0;
            ven_q     <= '0;
            dev_q     <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    eff_op    <= split_go ? OP_SECT : op_e'(op);
                    step      <= '0;
                    idx_q     <= index;
                    slog_q    <= sec_log2;
                    blog_q    <= blk_log2;
                    padr_q    <= prog_addr;
                    pdat_q    <= prog_data;
                    gap_q     <= poll_gap;
                    timeout_q <= 1'b0;
                    sec_cur   <= split_go ? (ADDR_W'(index) << diff) : ADDR_W'(index);
                    sec_left  <= split_go ? ((ADDR_W'(1) << diff) - ADDR_W'(1)) : '0;
                end
                S_ACCESS: begin
                    if (kind == K_END) begin
                        if (sec_left != '0) begin
                            sec_left <= sec_left - ADDR_W'(1);
                            sec_cur  <= sec_cur + ADDR_W'(1);
                            step     <= '0;
                        end
                    end else if (mem_ack) begin
                        last_kind <= kind;
                        if (kind == K_RD_VEN) ven_q <= mem_rdata;
                        if (kind == K_RD_DEV) dev_q <= mem_rdata;
                    end
                end
                S_ADVANCE: begin
                    if (step_adv)    step      <= step + STEP_W'(1);
                    else if (to_hit) timeout_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state == S_ACCESS) && (kind != K_END);
        mem_we    = mem_req && (kind == K_WR);
        mem_addr  = s_addr;
        mem_wdata = s_data;
        busy      = (state == S_ACCESS) || (state == S_ADVANCE) || (state == S_GAP);
        done      = (state == S_DONE);
        timeout   = timeout_q;
        ven_id    = ven_q;
        dev_id    = dev_q;
    end

    a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    a_r8_timeout_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> !mem_req);

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

    localparam int AW    = 20;
    localparam int LIMIT = 8;
    localparam logic [7:0] VEN = 8'hC2;
    localparam logic [7:0] DEV = 8'h3D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_i = '0;
    logic [7:0]  index_i = '0;
    logic [4:0]  slog_i = 5'd2, blog_i = 5'd2;
    logic        split_i = 1'b0;
    logic [AW-1:0] padr_i = '0;
    logic [7:0]  pdat_i = '0;
    logic [7:0]  gap_i = '0;
    logic        busy, done, timeout;
    logic [7:0]  ven_id, dev_id;
    logic        mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .IDX_W(8), .GAP_W(8), .POLL_LIMIT(LIMIT)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .index(index_i),
        .sec_log2(slog_i), .blk_log2(blog_i), .blk_split(split_i),
        .prog_addr(padr_i), .prog_data(pdat_i), .poll_gap(gap_i),
        .busy(busy), .done(done), .timeout(timeout), .ven_id(ven_id), .dev_id(dev_id),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- device model and access log ----------------
    logic [28:0] log_q [0:127];
    int          lowrun_q [0:127];
    int          nlog = 0;
    int          lowrun = 0;
    bit          id_mode = 0;
    int          busy_left = 0;
    bit          st = 0;
    int          plan_n = 0;
    bit          pending = 0;
    int          lat = 0;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!mem_req) lowrun++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!pending) begin
                    pending = 1;
                    lat = $urandom_range(0, 2);
                end
                if (lat == 0) begin
                    if (nlog < 128) begin
                        log_q[nlog]    = {mem_we, mem_addr, mem_wdata};
                        lowrun_q[nlog] = lowrun;
                        nlog++;
                    end
                    lowrun = 0;
                    if (mem_we) begin
                        if (mem_addr == 20'h05555 && mem_wdata == 8'h90) id_mode = 1;
                        if (mem_wdata == 8'hF0) id_mode = 0;
                        busy_left = plan_n;
                        mem_rdata = $urandom();
                    end else if (id_mode) begin
                        mem_rdata = (mem_addr == 0) ? VEN : (mem_addr == 1) ? DEV : 8'h00;
                    end else begin
                        if (busy_left > 0) begin
                            st = ~st;
                            busy_left--;
                        end
                        mem_rdata = $urandom();
                        mem_rdata[6] = st;
                    end
                    mem_ack = 1'b1;
                    pending = 0;
                end else begin
                    lat--;
                end
            end
        end
    end

    // ---------------- expected access stream ----------------
    logic [28:0] exp_q [0:127];
    bit          exp_poll [0:127];
    int          exp_len = 0;
    bit          exp_to = 0;

    task automatic push(bit w, logic [AW-1:0] a, logic [7:0] d, bit p);
        if (exp_len < 128) begin
            exp_q[exp_len]    = {w, a, d};
            exp_poll[exp_len] = p;
            exp_len++;
        end
    endtask

    task automatic push_polls(int n);
        int misses = (n < 1) ? 1 : n;
        int cnt;
        if (misses >= LIMIT) begin cnt = LIMIT; exp_to = 1; end
        else cnt = (n + 1 < 2) ? 2 : n + 1;
        for (int k = 0; k < cnt; k++) push(0, '0, '0, 1);
    endtask

    task automatic push_erase(logic [AW-1:0] a, logic [7:0] fin, int n);
        push(1, 20'h05555, 8'hAA, 0);
        push(1, 20'h02AAA, 8'h55, 0);
        push(1, 20'h05555, 8'h80, 0);
        push(1, 20'h05555, 8'hAA, 0);
        push(1, 20'h02AAA, 8'h55, 0);
        push(1, a, fin, 0);
        push_polls(n);
    endtask

    task automatic build(int op, int idx, int slog, int blog, bit split,
                         logic [AW-1:0] padr, logic [7:0] pdat, int n);
        exp_len = 0;
        exp_to  = 0;
        case (op)
            0: begin
                push(1, 20'h05555, 8'hAA, 0);
                push(1, 20'h02AAA, 8'h55, 0);
                push(1, 20'h05555, 8'h90, 0);
                push(0, 20'h00000, 8'h00, 0);
                push(0, 20'h00001, 8'h00, 0);
                push(1, 20'h00000, 8'hF0, 0);
            end
            1: begin
                push(1, 20'h05555, 8'hAA, 0);
                push(1, 20'h02AAA, 8'h55, 0);
                push(1, 20'h05555, 8'hA0, 0);
                push(1, padr, pdat, 0);
                push_polls(n);
            end
            2: push_erase(AW'(idx) << slog, 8'h30, n);
            3: begin
                if (split) begin
                    int d = blog - slog;
                    for (int s = idx << d; s < ((idx + 1) << d); s++) begin
                        if (!exp_to) push_erase(AW'(s) << slog, 8'h30, n);
                    end
                end else begin
                    push_erase(AW'(idx) << blog, 8'h50, n);
                end
            end
            4: push_erase(20'h05555, 8'h10, n);
            default: ;
        endcase
    endtask

    // ---------------- one operation ----------------
    task automatic run_op(int op, int idx, int slog, int blog, bit split,
                          logic [AW-1:0] padr, logic [7:0] pdat, int n, int gap,
                          bit inject, string tag);
        int cyc = 0;
        int bad = -1;
        int polls_seen = 0, polls_exp = 0;
        bit gap_ok = 1;
        int gap_act = 0;
        int gap_exp;
        @(negedge clk);
        op_i = 3'(op); index_i = 8'(idx); slog_i = 5'(slog); blog_i = 5'(blog);
        split_i = split; padr_i = padr; pdat_i = pdat; gap_i = 8'(gap);
        plan_n = n;
        nlog = 0;
        lowrun = 0;
        build(op, idx, slog, blog, split, padr, pdat, n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            @(negedge clk);
            @(negedge clk);
            op_i = 3'd4; index_i = 8'hFF; padr_i = ~padr; pdat_i = ~pdat; gap_i = 8'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 20000, tag, "operation completes", cyc, 0);
        chk(!busy, "R10", "busy low with done", busy, 0);
        chk(nlog == exp_len, tag, "access count", nlog, exp_len);
        for (int i = 0; i < nlog && i < exp_len; i++) begin
            bit mism = (log_q[i][28:8] != exp_q[i][28:8]) ||
                       (exp_q[i][28] && log_q[i][7:0] != exp_q[i][7:0]);
            if (mism && bad < 0) bad = i;
        end
        if (bad >= 0)
            chk(0, tag, "access stream entry", int'(log_q[bad]), int'(exp_q[bad]));
        else
            chk(1, tag, "access stream", 0, 0);
        if (op <= 4 && exp_len >= 2 && nlog >= 2)
            chk(log_q[0] == exp_q[0] && log_q[1] == exp_q[1], "R2", "unlock prefix",
                int'(log_q[1]), int'(exp_q[1]));
        for (int i = 0; i < nlog; i++) if (!log_q[i][28] && op != 0) polls_seen++;
        for (int i = 0; i < exp_len; i++) if (exp_poll[i]) polls_exp++;
        chk(polls_seen == polls_exp, "R6", "poll read count", polls_seen, polls_exp);
        chk(timeout == exp_to, "R8", "timeout flag", timeout, exp_to);
        gap_exp = (op >= 2) ? 1 + gap : 1;
        for (int i = 1; i < nlog && i < exp_len; i++) begin
            if (exp_poll[i] && exp_poll[i-1] && lowrun_q[i] != gap_exp && gap_ok) begin
                gap_ok = 0;
                gap_act = lowrun_q[i];
            end
        end
        if (polls_exp > 1)
            chk(gap_ok, "R7", "idle cycles between polls", gap_act, gap_exp);
        if (op == 0) begin
            chk(ven_id == VEN, "R3", "vendor byte", ven_id, VEN);
            chk(dev_id == DEV, "R3", "device byte", dev_id, DEV);
        end
        @(negedge clk);
        chk(!done, "R10", "done is one cycle", done, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #900us;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !timeout && !mem_req, "R1", "control outputs at reset",
            {busy, done, timeout, mem_req}, 0);
        chk(ven_id == 8'h00 && dev_id == 8'h00, "R1", "id bytes at reset",
            {ven_id, dev_id}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(0, 0, 2, 2, 0, '0, '0, 0, 0, 0, "R3");
        run_op(1, 0, 2, 2, 0, 20'h1234C, 8'h5A, 0, 0, 0, "R4");
        run_op(1, 0, 2, 2, 0, 20'h00ABC, 8'hC3, 5, 3, 0, "R4");
        run_op(2, 7, 3, 3, 0, '0, '0, 4, 2, 0, "R5");
        run_op(3, 2, 3, 5, 0, '0, '0, 7, 0, 0, "R5");
        run_op(4, 0, 2, 2, 0, '0, '0, 8, 1, 0, "R8");
        run_op(3, 3, 2, 4, 1, '0, '0, 2, 1, 0, "R9");
        run_op(6, 0, 2, 2, 0, '0, '0, 0, 0, 0, "R10");
        run_op(1, 0, 2, 2, 0, 20'h0F00F, 8'h81, 6, 0, 1, "R10");
        run_op(3, 1, 3, 4, 1, '0, '0, 9, 0, 0, "R9");

        for (int t = 0; t < 20; t++) begin
            int o    = $urandom_range(0, 5);
            int sl   = $urandom_range(2, 4);
            int bl   = sl + $urandom_range(0, 2);
            int ix   = $urandom_range(0, 15);
            int n    = $urandom_range(0, 9);
            int g    = $urandom_range(0, 3);
            bit sp   = 1'($urandom_range(0, 1));
            logic [AW-1:0] pa = AW'($urandom());
            logic [7:0]    pd = 8'($urandom());
            string tg = (o == 0) ? "R3" : (o == 1) ? "R4" : (o == 3 && sp) ? "R9" :
                        (o >= 5) ? "R10" : "R5";
            run_op(o, ix, sl, bl, sp, pa, pd, n, g, 0, tg);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule